// File: doc/BRIEF.md
# Banked Cumulative Frequency Table

This block keeps the cumulative occurrence counts that an adaptive multi-symbol arithmetic coder needs for a 256-symbol alphabet. The counts are split into 16 groups of 16 symbols. Each group keeps one absolute starting value in a register. A row of group-relative offsets sits in a small row-wide RAM. Because of this split, an occurrence change only touches the group starting values plus the one row that holds the symbol. A decode search needs only 16 comparisons on the starting values, then 16 more inside one row, rather than 256.

Three operations are offered. An increment adds one to a symbol's occurrence. It loads the symbol's row into working counters, updates them together with the group starting values, and writes the row back. When the total reaches a configured limit, a serial pass halves every occurrence, one group per cycle, and no occurrence falls to zero. A lookup returns the cumulative value and the frequency of a symbol, for the encoder. A search returns the symbol whose interval holds a code point, for the decoder. The encoder and decoder arithmetic sit outside the block.

Top module: `cumfreq_banks`

## Requirements
- R1: After reset the block is busy for 16 cycles while it fills its rows. It then reports a total of 256, and every symbol has occurrence 1.
- R2: A lookup (`req_op` = 2'b10) accepted while idle sets `rsp_valid` one cycle later. It returns `rsp_sym` = `req_sym`, `rsp_cum` = the sum of the occurrences of all smaller symbols, and `rsp_freq` = the symbol's occurrence. Bits 7:4 of a symbol pick its group and bits 3:0 pick its slot within the group.
- R3: An increment (`req_op` = 2'b01) raises the occurrence of `req_sym` and `total` by one each. `busy` stays high for exactly 2 cycles after acceptance, unless a halving pass follows.
- R4: A search (`req_op` = 2'b11) with `req_code` < `total` returns, one cycle later, the largest symbol whose cumulative value is at most `req_code`, together with its cumulative value and frequency.
- R5: When an increment brings `total` to `CUM_LIMIT`, every occurrence n becomes (n+1)/2 rounded down. This lengthens the busy time by 16 cycles, to 18 in all.
- R6: A request presented while `busy` is high is ignored. It gives no response and leaves every count unchanged.
- R7: Op code 2'b00 does nothing, and `rsp_valid` stays low.
- R8: No reported frequency is ever zero, and `total` never exceeds `CUM_LIMIT`.
- R9: Symbol 0 always has cumulative value 0. The frequency of symbol 255 is taken against `total`. A search for code 0 gives symbol 0, and a search for code `total`-1 gives the highest symbol with a nonzero share.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 none, 01 increment, 10 lookup, 11 search |
| req_sym | input | 8 | Symbol for increment or lookup |
| req_code | input | 14 | Code point for search |
| busy | output | 1 | High while requests are ignored |
| rsp_valid | output | 1 | Lookup or search result valid |
| rsp_sym | output | 8 | Result symbol |
| rsp_cum | output | 14 | Cumulative value of the result symbol |
| rsp_freq | output | 14 | Occurrence of the result symbol |
| total | output | 14 | Sum of all occurrences |

## Verification
A stale group starting value shifts `rsp_cum` for every symbol above that group. A lost row write-back shows up only on symbols inside that one group, so each full sweep looks up all 256 symbols and searches both ends of every interval. Either fault appears on the very next sweep after the increment that caused it. A halving error breaks the reference counts at once. It can also leave a zero-width interval, which shows as a zero frequency or as a search landing on the wrong symbol.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_INC  = 2'b01,
    OP_LOOK = 2'b10,
    OP_SRCH = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_UPD,
    ST_WB,
    ST_HALF
  } st_e;
endpackage

// File: rtl/cfb_row_ram.sv
module cfb_row_ram #(
  parameter int NBANK  = 16,
  parameter int NPOS   = 16,
  parameter int WORD_W = 14,
  localparam int BNK_W = $clog2(NBANK)
) (
  input  logic                        clk,
  input  logic [BNK_W-1:0]            rd_addr,
  output logic [NPOS-1:0][WORD_W-1:0] rd_row,
  input  logic                        wr_en,
  input  logic [BNK_W-1:0]            wr_addr,
  input  logic [NPOS-1:0][WORD_W-1:0] wr_row
);
  logic [NPOS-1:0][WORD_W-1:0] mem [NBANK];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_row;
  end

  assign rd_row = mem[rd_addr];
endmodule

// File: rtl/cfb_search.sv
module cfb_search #(
  parameter int NBANK  = 16,
  parameter int NPOS   = 16,
  parameter int WORD_W = 14,
  localparam int BNK_W = $clog2(NBANK),
  localparam int POS_W = $clog2(NPOS)
) (
  input  logic [NBANK-1:0][WORD_W-1:0] bases,
  input  logic [WORD_W-1:0]            code,
  input  logic [NPOS-1:0][WORD_W-1:0]  row,
  output logic [BNK_W-1:0]             bank,
  output logic [POS_W-1:0]             pos
);
  logic [WORD_W-1:0] rel;

  // first level: group whose starting value lies at or below the code
  always_comb begin
    bank = '0;
    for (int b = 0; b < NBANK; b++)
      if (bases[b] <= code) bank = BNK_W'(b);
  end

  assign rel = code - bases[bank];

  // second level: slot inside the chosen group
  always_comb begin
    pos = '0;
    for (int j = 0; j < NPOS; j++)
      if (row[j] <= rel) pos = POS_W'(j);
  end
endmodule

// File: rtl/cfb_interval.sv
module cfb_interval #(
  parameter int NBANK  = 16,
  parameter int NPOS   = 16,
  parameter int WORD_W = 14,
  localparam int BNK_W = $clog2(NBANK),
  localparam int POS_W = $clog2(NPOS)
) (
  input  logic [NBANK-1:0][WORD_W-1:0] bases,
  input  logic [WORD_W-1:0]            total,
  input  logic [NPOS-1:0][WORD_W-1:0]  row,
  input  logic [BNK_W-1:0]             bank,
  input  logic [POS_W-1:0]             pos,
  output logic [WORD_W-1:0]            cum,
  output logic [WORD_W-1:0]            freq
);
  logic [WORD_W-1:0] nxt;

  assign cum = bases[bank] + row[pos];

  always_comb begin
    if (pos != POS_W'(NPOS - 1))       nxt = bases[bank] + row[pos + 1'b1];
    else if (bank != BNK_W'(NBANK - 1)) nxt = bases[bank + 1'b1];
    else                               nxt = total;
  end

  assign freq = nxt - cum;
endmodule

// File: rtl/cfb_halve.sv
module cfb_halve #(
  parameter int NPOS   = 16,
  parameter int WORD_W = 14
) (
  input  logic [NPOS-1:0][WORD_W-1:0] row,
  input  logic [WORD_W-1:0]           base_lo,
  input  logic [WORD_W-1:0]           upper,
  output logic [NPOS-1:0][WORD_W-1:0] new_row,
  output logic [WORD_W-1:0]           bank_sum
);
  logic [WORD_W-1:0] occ  [NPOS];
  logic [WORD_W-1:0] hocc [NPOS];

  for (genvar j = 0; j < NPOS; j++) begin : g_occ
    if (j == NPOS - 1) begin : g_last
      assign occ[j] = (upper - base_lo) - row[j];
    end else begin : g_mid
      assign occ[j] = row[j+1] - row[j];
    end
    assign hocc[j] = (occ[j] + 1'b1) >> 1;
  end

  always_comb begin
    logic [WORD_W-1:0] run;
    run = '0;
    for (int j = 0; j < NPOS; j++) begin
      new_row[j] = run;
      run = run + hocc[j];
    end
    bank_sum = run;
  end
endmodule

// File: rtl/cumfreq_banks.sv
module cumfreq_banks #(
  parameter int SYM_W     = 8,
  parameter int POS_W     = 4,
  parameter int WORD_W    = 14,
  parameter int CUM_LIMIT = 16000,
  localparam int BNK_W = SYM_W - POS_W,
  localparam int NBANK = 1 << BNK_W,
  localparam int NPOS  = 1 << POS_W,
  localparam int NSYM  = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [SYM_W-1:0]  req_sym,
  input  logic [WORD_W-1:0] req_code,
  output logic              busy,
  output logic              rsp_valid,
  output logic [SYM_W-1:0]  rsp_sym,
  output logic [WORD_W-1:0] rsp_cum,
  output logic [WORD_W-1:0] rsp_freq,
  output logic [WORD_W-1:0] total
);
  import cfb_pkg::*;

  typedef logic [NPOS-1:0][WORD_W-1:0] row_t;

  st_e                         state_q, state_d;
  logic [BNK_W-1:0]            hcnt_q, hcnt_d;
  row_t                        work_q, work_d;
  logic [NBANK-1:0][WORD_W-1:0] bases_q, bases_d;
  logic [WORD_W-1:0]           total_q, total_d, acc_q, acc_d;
  logic [SYM_W-1:0]            sym_q, sym_d;
  logic                        rsp_valid_d;
  logic [SYM_W-1:0]            rsp_sym_d;
  logic [WORD_W-1:0]           rsp_cum_d, rsp_freq_d;

  op_e               op;
  logic [BNK_W-1:0]  rd_bank, wr_bank, srch_bank, iv_bank;
  logic [POS_W-1:0]  srch_pos, iv_pos;
  row_t              rd_row, wr_row, init_row, half_row;
  logic              wr_en;
  logic [WORD_W-1:0] iv_cum, iv_freq, half_sum, half_upper;

  assign op = op_e'(req_op);

  cfb_row_ram #(.NBANK(NBANK), .NPOS(NPOS), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .rd_addr(rd_bank), .rd_row(rd_row),
    .wr_en(wr_en), .wr_addr(wr_bank), .wr_row(wr_row)
  );

  cfb_search #(.NBANK(NBANK), .NPOS(NPOS), .WORD_W(WORD_W)) u_search (
    .bases(bases_q), .code(req_code), .row(rd_row),
    .bank(srch_bank), .pos(srch_pos)
  );

  assign iv_bank = (op == OP_SRCH) ? srch_bank : req_sym[SYM_W-1:POS_W];
  assign iv_pos  = (op == OP_SRCH) ? srch_pos  : req_sym[POS_W-1:0];

  cfb_interval #(.NBANK(NBANK), .NPOS(NPOS), .WORD_W(WORD_W)) u_iv (
    .bases(bases_q), .total(total_q), .row(rd_row),
    .bank(iv_bank), .pos(iv_pos), .cum(iv_cum), .freq(iv_freq)
  );

  assign half_upper = (hcnt_q != BNK_W'(NBANK - 1)) ? bases_q[hcnt_q + 1'b1] : total_q;

  cfb_halve #(.NPOS(NPOS), .WORD_W(WORD_W)) u_halve (
    .row(rd_row), .base_lo(bases_q[hcnt_q]), .upper(half_upper),
    .new_row(half_row), .bank_sum(half_sum)
  );

  always_comb begin
    for (int j = 0; j < NPOS; j++) init_row[j] = WORD_W'(j);
  end

  // read address: halving walks the groups, search follows its own pick
  always_comb begin
    if (state_q == ST_HALF)  rd_bank = hcnt_q;
    else if (op == OP_SRCH)  rd_bank = srch_bank;
    else                     rd_bank = req_sym[SYM_W-1:POS_W];
  end

  always_comb begin
    state_d = state_q;  hcnt_d = hcnt_q;  work_d = work_q;
    bases_d = bases_q;  total_d = total_q; acc_d = acc_q; sym_d = sym_q;
    rsp_valid_d = 1'b0; rsp_sym_d = rsp_sym; rsp_cum_d = rsp_cum; rsp_freq_d = rsp_freq;
    wr_en = 1'b0; wr_bank = hcnt_q; wr_row = half_row;
    unique case (state_q)
      ST_INIT: begin
        wr_en = 1'b1; wr_row = init_row;
        hcnt_d = hcnt_q + 1'b1;
        if (hcnt_q == BNK_W'(NBANK - 1)) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          unique case (op)
            OP_INC: begin
              sym_d = req_sym; work_d = rd_row; state_d = ST_UPD;
            end
            OP_LOOK, OP_SRCH: begin
              rsp_valid_d = 1'b1;
              rsp_sym_d   = {iv_bank, iv_pos};
              rsp_cum_d   = iv_cum;
              rsp_freq_d  = iv_freq;
            end
            default: ;
          endcase
        end
      end
      ST_UPD: begin
        for (int j = 0; j < NPOS; j++)
          work_d[j] = work_q[j] + WORD_W'(POS_W'(j) > sym_q[POS_W-1:0]);
        for (int b = 0; b < NBANK; b++)
          bases_d[b] = bases_q[b] + WORD_W'(BNK_W'(b) > sym_q[SYM_W-1:POS_W]);
        total_d = total_q + 1'b1;
        state_d = ST_WB;
      end
      ST_WB: begin
        wr_en = 1'b1; wr_bank = sym_q[SYM_W-1:POS_W]; wr_row = work_q;
        if (total_q >= WORD_W'(CUM_LIMIT)) begin
          state_d = ST_HALF; hcnt_d = '0; acc_d = '0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HALF: begin
        wr_en = 1'b1;
        bases_d[hcnt_q] = acc_q;
        acc_d  = acc_q + half_sum;
        hcnt_d = hcnt_q + 1'b1;
        if (hcnt_q == BNK_W'(NBANK - 1)) begin
          total_d = acc_q + half_sum;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      hcnt_q    <= '0;
      work_q    <= '0;
      for (int b = 0; b < NBANK; b++) bases_q[b] <= WORD_W'(b * NPOS);
      total_q   <= WORD_W'(NSYM);
      acc_q     <= '0;
      sym_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_sym   <= '0;
      rsp_cum   <= '0;
      rsp_freq  <= '0;
    end else begin
      state_q   <= state_d;
      hcnt_q    <= hcnt_d;
      work_q    <= work_d;
      bases_q   <= bases_d;
      total_q   <= total_d;
      acc_q     <= acc_d;
      sym_q     <= sym_d;
      rsp_valid <= rsp_valid_d;
      if (rsp_valid_d) begin
        rsp_sym  <= rsp_sym_d;
        rsp_cum  <= rsp_cum_d;
        rsp_freq <= rsp_freq_d;
      end
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign total = total_q;

  AST_RSP_FREQ_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_freq != '0);                                           // R8
  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= WORD_W'(CUM_LIMIT));                                          // R8
  AST_RSP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ({1'b0, rsp_cum} + {1'b0, rsp_freq}) <= {1'b0, total_q});  // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_UPD |=> total_q == $past(total_q) + 1'b1);                 // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !rsp_valid);                                                    // R6
  AST_BASE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bases_q[0] == '0);                                                       // R9
  AST_SRCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op) == 2'b11 && $past(req_code) < total_q) |->
      (rsp_cum <= $past(req_code) &&
       {1'b0, $past(req_code)} < {1'b0, rsp_cum} + {1'b0, rsp_freq}));       // R4
endmodule

// File: tb/tb_cumfreq_banks.sv
module tb_cumfreq_banks;
  localparam int LIM = 600;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [7:0]  req_sym;
  logic [13:0] req_code;
  logic        busy, rsp_valid;
  logic [7:0]  rsp_sym;
  logic [13:0] rsp_cum, rsp_freq, total;

  int occ [256];
  int checks, errors;
  bit finished;

  cumfreq_banks #(.CUM_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_sym(req_sym), .req_code(req_code), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_sym(rsp_sym), .rsp_cum(rsp_cum), .rsp_freq(rsp_freq), .total(total)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ref_cum(int s);
    int c = 0;
    for (int i = 0; i < s; i++) c += occ[i];
    return c;
  endfunction

  function automatic int ref_tot();
    return ref_cum(256);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic lookup(int s, string req);
    @(negedge clk);
    req_valid = 1; req_op = 2'b10; req_sym = 8'(s);
    @(negedge clk);
    req_valid = 0; req_op = 2'b00;
    chk(rsp_valid == 1, req, "lookup valid", int'(rsp_valid), 1);
    chk(int'(rsp_sym) == s, req, "lookup sym", int'(rsp_sym), s);
    chk(int'(rsp_cum) == ref_cum(s), req, "lookup cum", int'(rsp_cum), ref_cum(s));
    chk(int'(rsp_freq) == occ[s], req, "lookup freq", int'(rsp_freq), occ[s]);
  endtask

  task automatic search(int code, string req);
    int es = 0;
    for (int s = 0; s < 256; s++) if (ref_cum(s) <= code && occ[s] > 0) es = s;
    @(negedge clk);
    req_valid = 1; req_op = 2'b11; req_code = 14'(code);
    @(negedge clk);
    req_valid = 0; req_op = 2'b00;
    chk(rsp_valid == 1, req, "search valid", int'(rsp_valid), 1);
    chk(int'(rsp_sym) == es, req, "search sym", int'(rsp_sym), es);
    chk(int'(rsp_cum) == ref_cum(es), req, "search cum", int'(rsp_cum), ref_cum(es));
    chk(int'(rsp_freq) == occ[es], req, "search freq", int'(rsp_freq), occ[es]);
  endtask

  task automatic inc(int s, output int nbusy);
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_sym = 8'(s);
    @(negedge clk);
    req_valid = 0; req_op = 2'b00;
    nbusy = 0;
    while (busy && nbusy < 100) begin nbusy++; @(negedge clk); end
    occ[s]++;
    if (ref_tot() >= LIM)
      for (int i = 0; i < 256; i++) occ[i] = (occ[i] + 1) / 2;
  endtask

  task automatic scan(string req);
    int c;
    for (int s = 0; s < 256; s++) begin
      lookup(s, req);
      c = ref_cum(s);
      search(c, req);
      search(c + occ[s] - 1, req);
    end
    chk(int'(total) == ref_tot(), req, "total", int'(total), ref_tot());
  endtask

  task automatic t_reset();
    int n = 0;
    rst_n = 0; req_valid = 0; req_op = 0; req_sym = 0; req_code = 0;
    for (int i = 0; i < 256; i++) occ[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1, "R1", "busy after reset", int'(busy), 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == 15, "R1", "init busy cycles after first", n, 15);
    chk(int'(total) == 256, "R1", "total after init", int'(total), 256);
  endtask

  task automatic t_increments();
    int nb;
    int syms [8] = '{0, 255, 17, 17, 17, 15, 16, 128};
    foreach (syms[k]) begin
      inc(syms[k], nb);
      chk(nb == 2, "R3", "increment busy cycles", nb, 2);
      chk(int'(total) == ref_tot(), "R3", "total after increment", int'(total), ref_tot());
    end
    scan("R2");
  endtask

  task automatic t_edges();
    search(0, "R9");
    search(ref_tot() - 1, "R9");
    lookup(0, "R9");
    lookup(255, "R9");
  endtask

  task automatic t_busy_ignore();
    int t0;
    t0 = ref_tot();
    @(negedge clk);
    req_valid = 1; req_op = 2'b01; req_sym = 8'd40;
    @(negedge clk);
    req_op = 2'b10; req_sym = 8'd3;
    @(negedge clk);
    chk(rsp_valid == 0, "R6", "lookup while busy answered", int'(rsp_valid), 0);
    req_op = 2'b01; req_sym = 8'd41;
    @(negedge clk);
    req_valid = 0; req_op = 2'b00;
    chk(busy == 0, "R6", "busy after increment", int'(busy), 0);
    occ[40]++;
    chk(int'(total) == t0 + 1, "R6", "total after ignored inc", int'(total), t0 + 1);
    lookup(41, "R6");
    lookup(40, "R6");
  endtask

  task automatic t_noop();
    int t0;
    t0 = int'(total);
    @(negedge clk);
    req_valid = 1; req_op = 2'b00; req_sym = 8'd9;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 0, "R7", "noop response", int'(rsp_valid), 0);
    chk(busy == 0, "R7", "noop busy", int'(busy), 0);
    chk(int'(total) == t0, "R7", "noop total", int'(total), t0);
  endtask

  task automatic t_halving(int s);
    int nb = 0;
    int guard = 0;
    while (ref_tot() + 1 < LIM && guard < 1000) begin inc(s, nb); guard++; end
    inc(s, nb);
    chk(nb == 18, "R5", "halving busy cycles", nb, 18);
    chk(int'(total) == ref_tot(), "R5", "total after halving", int'(total), ref_tot());
    chk(int'(total) < LIM, "R8", "total within limit", int'(total), LIM - 1);
    scan("R5");
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    t_reset();
    scan("R1");
    t_increments();
    t_edges();
    t_busy_ignore();
    t_noop();
    t_halving(5);
    t_halving(255);
    t_edges();
    search(ref_cum(100) + occ[100] / 2, "R4");
    summary();
  end
endmodule